// File: doc/BRIEF.md
# SIMD Immediate Shift Lane Unit

This block shifts every lane of a vector operand by an immediate amount and writes a new destination vector. The vector is 128 bits wide. A lane can be 8, 16, 32 or 64 bits. The operations are a logical left shift, logical and arithmetic right shifts, a rounding arithmetic right shift, right shifts that add into the old destination lane (signed and unsigned), and a left shift that inserts into the old destination lane. Decode, immediate extraction and register file access happen outside the block. The caller presents the source vector, the old destination, the lane size code, the shift amount and the operation on a single valid strobe.

Two flags set how much of the result is written. With `wide` clear the operation is a 64-bit one: only the lower half is computed and the upper half comes out as zero. With `scalar` set, only lane 0 is computed and every other bit of the result is zero. Each lane is computed apart from the others. A lane result is cut to the lane width, so a carry never crosses into the next lane. The result is registered and appears one cycle after the strobe, together with a one-cycle done pulse.

Top module: `vshift_imm_unit`

## Requirements
- R1: `lsz` sets the lane width: 0 is 8 bits, 1 is 16, 2 is 32, 3 is 64. The lane count is (vector bytes) >> `lsz`. Lane i takes bits [i*W +: W]. Operation code 7 yields all-zero lanes.
- R2: With `wide`=0, result bits 127:64 are zero, and lanes are computed only in bits 63:0.
- R3: Op 0 (left shift) zero-extends the lane and shifts it left. Bits leaving the lane are lost. A shift of W or more gives 0.
- R4: Op 1 is a logical right shift with zero fill. Op 2 is an arithmetic right shift with sign fill. A shift larger than W acts as a shift by W: 0 for op 1, all sign bits for op 2.
- R5: Op 3 (rounding right shift) adds 1<<(s-1) to the sign-extended lane and then shifts arithmetically by s. With s=0 the lane passes through unchanged.
- R6: Op 4 adds the logical right shift of the source lane to the old destination lane. Op 5 adds the arithmetic right shift. Both wrap modulo 2^W.
- R7: Op 6 (insert) gives (src<<s) OR (old destination AND ((1<<s)-1)). With s=0 the mask is empty. With s of W or more the old lane is kept.
- R8: With `scalar`=1, only lane 0 is computed and all other result bits are zero.
- R9: `result` is updated on the clock edge after `in_valid` is sampled high. `out_valid` is high for exactly that one cycle.
- R10: While `in_valid` is low, `result` holds its value.
- R11: While `rst_n` is low, `result` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (see R1..R7) |
| lsz | input | 2 | Lane size code |
| wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| scalar | input | 1 | Lane-0-only form |
| shamt | input | 7 | Immediate shift amount |
| src | input | 128 | Source vector |
| dst_old | input | 128 | Old destination vector |
| out_valid | output | 1 | Done pulse, one cycle after the strobe |
| result | output | 128 | New destination vector |

## Verification
For every operation and every lane size, the sweep tries each shift amount from 0 to one past the lane width, in both 64-bit and 128-bit modes. Zero and over-width shifts separate the saturation and empty-mask cases from ordinary shifts. Each point runs with random data and with a pattern whose lanes have the sign bit set. The sign pattern separates arithmetic from logical fill and exposes rounding and wrap-around errors. The 64-bit and 128-bit modes show whether the upper half is cleared. The lane boundaries show whether a carry leaks into the next lane. Scalar runs at every lane size check that only lane 0 is written.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
   localparam int SH_W = 7;

   typedef enum logic [2:0] {
      OP_SHL   = 3'd0,
      OP_USHR  = 3'd1,
      OP_SSHR  = 3'd2,
      OP_SRSHR = 3'd3,
      OP_USRA  = 3'd4,
      OP_SSRA  = 3'd5,
      OP_SLI   = 3'd6,
      OP_NONE  = 3'd7
   } vsh_op_e;
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane
   import vshift_pkg::*;
#(
   parameter int LW = 8
) (
   input  vsh_op_e          op,
   input  logic [SH_W-1:0]  shamt,
   input  logic [LW-1:0]    x,
   input  logic [LW-1:0]    d,
   output logic [LW-1:0]    r
);
   localparam int EW = LW + 2;
   localparam logic [SH_W-1:0] LIM = SH_W'(LW);
   localparam logic [EW-1:0]   ONE = EW'(1);

   generate
      if (LW < 8 || LW > 64) begin : g_bad_lw
         $error("vshift_lane: lane width out of range");
      end
   endgenerate

   logic [SH_W-1:0]      shc;
   logic [EW-1:0]        xz;
   logic signed [EW-1:0] xs;
   logic [EW-1:0]        rnd;
   logic [EW-1:0]        msk;
   logic [EW-1:0]        sl;
   logic [EW-1:0]        srl;
   logic signed [EW-1:0] sra;
   logic signed [EW-1:0] rsra;

   always_comb begin
      // shifts beyond the lane width saturate at the lane width
      shc  = (shamt > LIM) ? LIM : shamt;
      xz   = {2'b00, x};
      xs   = {{2{x[LW-1]}}, x};
      rnd  = (shc == '0) ? '0 : (ONE << (shc - SH_W'(1)));
      msk  = (ONE << shc) - ONE;
      sl   = xz << shc;
      srl  = xz >> shc;
      sra  = xs >>> shc;
      rsra = $signed(xs + $signed(rnd)) >>> shc;
   end

   always_comb begin
      unique case (op)
         OP_SHL:   r = sl[LW-1:0];
         OP_USHR:  r = srl[LW-1:0];
         OP_SSHR:  r = sra[LW-1:0];
         OP_SRSHR: r = rsra[LW-1:0];
         OP_USRA:  r = d + srl[LW-1:0];
         OP_SSRA:  r = d + sra[LW-1:0];
         OP_SLI:   r = sl[LW-1:0] | (d & msk[LW-1:0]);
         default:  r = '0;
      endcase
   end
endmodule

// File: rtl/vshift_lane_array.sv
module vshift_lane_array
   import vshift_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int LW    = 8
) (
   input  vsh_op_e           op,
   input  logic [SH_W-1:0]   shamt,
   input  logic              wide,
   input  logic              scalar,
   input  logic [VEC_W-1:0]  src,
   input  logic [VEC_W-1:0]  dst_old,
   output logic [VEC_W-1:0]  vec
);
   localparam int NL      = VEC_W / LW;
   localparam int NL_HALF = NL / 2;

   generate
      if (VEC_W % (2 * LW) != 0) begin : g_bad_split
         $error("vshift_lane_array: vector does not split into lane pairs");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NL; gi++) begin : g_lane
         logic [LW-1:0] lr;
         logic          act;

         vshift_lane #(.LW(LW)) i_lane (
            .op    (op),
            .shamt (shamt),
            .x     (src[gi*LW +: LW]),
            .d     (dst_old[gi*LW +: LW]),
            .r     (lr)
         );

         if (gi == 0) begin : g_first
            assign act = 1'b1;
         end else if (gi < NL_HALF) begin : g_low
            assign act = !scalar;
         end else begin : g_high
            assign act = !scalar && wide;
         end

         assign vec[gi*LW +: LW] = act ? lr : '0;
      end
   endgenerate
endmodule

// File: rtl/vshift_imm_unit.sv
module vshift_imm_unit
   import vshift_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic [1:0]        lsz,
   input  logic              wide,
   input  logic              scalar,
   input  logic [SH_W-1:0]   shamt,
   input  logic [VEC_W-1:0]  src,
   input  logic [VEC_W-1:0]  dst_old,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result
);
   localparam int NSZ  = 4;
   localparam int HALF = VEC_W / 2;

   generate
      if (VEC_W % 128 != 0) begin : g_bad_vec
         $error("vshift_imm_unit: vector width must be a multiple of 128");
      end
   endgenerate

   vsh_op_e          op_e;
   logic [VEC_W-1:0] size_vec [NSZ];
   logic [VEC_W-1:0] nxt;

   assign op_e = vsh_op_e'(op);

   genvar gs;
   generate
      for (gs = 0; gs < NSZ; gs++) begin : g_size
         vshift_lane_array #(.VEC_W(VEC_W), .LW(8 << gs)) i_arr (
            .op      (op_e),
            .shamt   (shamt),
            .wide    (wide),
            .scalar  (scalar),
            .src     (src),
            .dst_old (dst_old),
            .vec     (size_vec[gs])
         );
      end
   endgenerate

   assign nxt = size_vec[lsz];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt;
      end
   end

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide) |=> (result[VEC_W-1:HALF] == '0));
   p_scalar_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && scalar) |=> (result[VEC_W-1:64] == '0));
endmodule

// File: tb/test_vshift_imm_unit.sv
`timescale 1ns/1ps
module test_vshift_imm_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [2:0]   op = '0;
   logic [1:0]   lsz = '0;
   logic         wide = 1'b0;
   logic         scalar = 1'b0;
   logic [6:0]   shamt = '0;
   logic [127:0] src = '0;
   logic [127:0] dst_old = '0;
   logic         out_valid;
   logic [127:0] result;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   vshift_imm_unit i_vshift_imm_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lsz(lsz),
      .wide(wide), .scalar(scalar), .shamt(shamt), .src(src),
      .dst_old(dst_old), .out_valid(out_valid), .result(result)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s op=%0d lsz=%0d wide=%0d scalar=%0d sh=%0d act=%h exp=%h",
                  req, op, lsz, wide, scalar, shamt, act, exp);
      end
   endtask

   function automatic logic [63:0] mlane(int o, int L, logic [63:0] xin, logic [63:0] din, int sh);
      logic [127:0] m;
      logic [127:0] x, d, v;
      logic signed [127:0] xs;
      int s;
      m  = (128'd1 << L) - 128'd1;
      x  = {64'd0, xin} & m;
      d  = {64'd0, din} & m;
      xs = x;
      if (x[L-1]) xs = xs - (128'sd1 <<< L);
      s  = (sh > L) ? L : sh;
      case (o)
         0: v = (sh >= L) ? 128'd0 : (x << sh);
         1: v = (sh >= L) ? 128'd0 : (x >> sh);
         2: v = xs >>> s;
         3: v = (s == 0) ? xs : ((xs + (128'sd1 <<< (s - 1))) >>> s);
         4: v = d + ((sh >= L) ? 128'd0 : (x >> sh));
         5: v = d + (xs >>> s);
         6: v = (sh >= L) ? d : ((x << sh) | (d & ((128'd1 << sh) - 128'd1)));
         default: v = 128'd0;
      endcase
      v = v & m;
      return v[63:0];
   endfunction

   function automatic logic [127:0] mvec(int o, int sz, bit w, bit sc, int sh,
                                         logic [127:0] s, logic [127:0] d);
      logic [127:0] r;
      int L, n;
      L = 8 << sz;
      n = sc ? 1 : ((w ? 128 : 64) / L);
      r = '0;
      for (int i = 0; i < n; i++) begin
         logic [63:0] lv;
         lv = mlane(o, L, s[i*L +: 64], d[i*L +: 64], sh);
         for (int b = 0; b < L; b++) r[i*L + b] = lv[b];
      end
      return r;
   endfunction

   task automatic run(input string req, input int o, input int sz, input bit w,
                      input bit sc, input int sh, input logic [127:0] s,
                      input logic [127:0] d);
      logic [127:0] exp;
      exp = mvec(o, sz, w, sc, sh, s, d);
      @(negedge clk);
      op = 3'(o); lsz = 2'(sz); wide = w; scalar = sc; shamt = 7'(sh);
      src = s; dst_old = d; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 done", {127'd0, out_valid}, 128'd1);
      check(req, result, exp);
      src = ~s; dst_old = ~d;
      @(negedge clk);
      check("R9 done low", {127'd0, out_valid}, 128'd0);
      check("R10 hold", result, exp);
   endtask

   function automatic string req_of(int o);
      case (o)
         0: return "R3 shl";
         1: return "R4 ushr";
         2: return "R4 sshr";
         3: return "R5 round";
         4: return "R6 usra";
         5: return "R6 ssra";
         6: return "R7 insert";
         default: return "R1 op7";
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [127:0] sgn [4];
      sgn[0] = {16{8'h81}};
      sgn[1] = {8{16'h8001}};
      sgn[2] = {4{32'hC000_0001}};
      sgn[3] = {2{64'h8000_0000_0000_00FF}};
      repeat (3) @(negedge clk);
      // R11: reset state, with a strobe applied during reset
      in_valid = 1'b1; src = '1;
      @(negedge clk);
      check("R11 reset result", result, 128'd0);
      check("R11 reset done", {127'd0, out_valid}, 128'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      // main sweep: R1 lane geometry, R2 half clear, R3..R7 per op
      for (int o = 0; o < 7; o++)
         for (int sz = 0; sz < 4; sz++)
            for (int sh = 0; sh <= (8 << sz) + 1; sh++)
               for (int w = 0; w < 2; w++) begin
                  logic [127:0] rs, rd;
                  rs = {$urandom, $urandom, $urandom, $urandom};
                  rd = {$urandom, $urandom, $urandom, $urandom};
                  run(w ? req_of(o) : "R2 narrow", o, sz, w[0], 1'b0, sh, rs, rd);
                  run(req_of(o), o, sz, w[0], 1'b0, sh, sgn[sz], ~sgn[sz]);
               end
      // R8: scalar form at each lane size
      for (int sz = 0; sz < 4; sz++)
         for (int o = 0; o < 7; o++)
            run("R8 scalar", o, sz, 1'b1, 1'b1, 3, '1, sgn[sz]);
      // R1: unused op code gives zero lanes
      run("R1 op7", 7, 1, 1'b1, 1'b0, 2, '1, '1);
      // R6: wrap-around of the accumulate
      run("R6 wrap", 4, 0, 1'b1, 1'b0, 1, {16{8'hFE}}, {16{8'hFF}});
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule